// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Indicator

This block compares two pulse trains that are synchronous to the system clock. One is a reference pulse train; the other comes from a feedback divider. It tells a charge pump which way to move the loop. The result goes out on two paths. The first is a three-state pump control code for an on-chip pump. The second is a pair of external-pump signals: a push-pull level and an open-drain pull-down that is either active or released. A polarity input reverses the sense of both paths, so the block can drive oscillators whose tuning slope has either sign. A correction pulse lasts exactly as many clock cycles as the two rising edges are apart.

A two-flop lead/lag state machine records which input rose first. It holds that state until the other input rises, so a frequency error also produces a correction of the right sign. A lock indicator counts consecutive comparisons whose correction pulse is short enough. It rises after a set number of them and falls as soon as one pulse grows too long.

When the run input is low, the block is in power save. Every output is parked at the value it has when the loop is locked, and the comparator state is cleared. When the run input goes high again, comparison starts from a clean state, so no stale pulse reaches the pump.

Top module: `pfd_lock`

## Requirements
- R1: While reset is held and right after it, `pump_code` is 2'b00 (high-Z), `ext_r` is 0, `ext_p_pull` is 0 (released) and `lock_out` is 0.
- R2: With `pol_swap` low, `pump_code` is 2'b10 (drive high) while the reference leads, 2'b01 (drive low) while the divided input leads, and 2'b00 (high-Z) when neither leads.
- R3: With `pol_swap` high, the two driving codes swap: the reference leading gives 2'b01 and the divided input leading gives 2'b10. High-Z is unchanged.
- R4: With `pol_swap` low, the reference leading gives `ext_r`=0 and `ext_p_pull`=1. The divided input leading gives `ext_r`=1 and `ext_p_pull`=0. No lead gives `ext_r`=0 and `ext_p_pull`=0.
- R5: With `pol_swap` high, the reference leading gives `ext_r`=1 and `ext_p_pull`=0. The divided input leading gives `ext_r`=0 and `ext_p_pull`=1. No lead gives both at 0.
- R6: Only rising edges count. A lead starts on the clock edge that samples the leading input's rise and ends on the edge that samples the other input's rise. When the rises are D cycles apart, the lead outputs stay active for exactly D cycles.
- R7: A further rise of the leading input during a lead leaves the lead pending until the other input rises. Rises of both inputs on the same edge give no active output.
- R8: `lock_out` goes to 1 after LOCK_CNT consecutive (default 3) completed comparisons whose lead lasts at most ERR_MAX cycles (default 4). It becomes visible in the cycle after the edge that ends the qualifying comparison.
- R9: When a lead lasts longer than ERR_MAX cycles, `lock_out` goes to 0 in the cycle after the edge that completes its ERR_MAX+1-th active cycle, and the qualifying count restarts from zero.
- R10: While `run_en` is 0, `pump_code` is 2'b00, `ext_r` is 0, `ext_p_pull` is 0 and `lock_out` is 1, whatever the inputs do.
- R11: After `run_en` returns to 1, no lead that was pending before power save and no edge seen during it is visible, and `lock_out` stays 0 until R8 is met again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference pulse train |
| div_in | input | 1 | Divided feedback pulse train |
| pol_swap | input | 1 | 1 reverses the sense of all pump outputs |
| run_en | input | 1 | 1 for normal operation, 0 for power save |
| pump_code | output | 2 | On-chip pump control: 00 high-Z, 01 drive low, 10 drive high |
| ext_r | output | 1 | Push-pull external-pump level |
| ext_p_pull | output | 1 | Open-drain external-pump control: 1 pulls low, 0 released |
| lock_out | output | 1 | Lock indicator |

## Verification
The assertions check on every cycle these points of the state machine: a lead only begins on a sampled rise of its own input, a pending lead holds until the opposing rise, power save clears the lead state, lock only rises after a qualifying resolution, and an overlong lead always clears lock. Only the bench scenarios can show the output coding under both polarities. They also show the exact pulse length in cycles, the timing of lock acquisition and loss over sequences of comparisons, and that nothing leaks out after a power-save exit.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    typedef enum logic [1:0] {
        PUMP_OFF  = 2'b00,
        PUMP_SINK = 2'b01,
        PUMP_SRC  = 2'b10
    } pump_code_e;

    typedef struct packed {
        logic up;
        logic dn;
    } lead_state_t;

endpackage

// File: rtl/pcl_edge.sv
module pcl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
        rise   = sig_in & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pcl_pfd.sv
module pcl_pfd
    import pcl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic ref_rise,
    input  logic div_rise,
    output logic up_q,
    output logic dn_q,
    output logic resolve
);
    lead_state_t st_d, st_q;
    logic up_set, dn_set;

    always_comb begin
        up_set  = st_q.up | ref_rise;
        dn_set  = st_q.dn | div_rise;
        resolve = run_en & up_set & dn_set;
        st_d.up = run_en & up_set & ~resolve;
        st_d.dn = run_en & dn_set & ~resolve;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_q = st_q.up;
    assign dn_q = st_q.dn;

    // R6
    up_starts_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_q) |-> $past(ref_rise));
    // R6
    dn_starts_on_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_q) |-> $past(div_rise));
    // R7
    up_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !div_rise && run_en) |=> up_q);
endmodule

// File: rtl/pcl_lockdet.sv
module pcl_lockdet #(
    parameter int ERR_MAX  = 4,
    parameter int LOCK_CNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic active,
    input  logic resolve,
    output logic lock_q
);
    localparam int EW = $clog2(ERR_MAX + 1);
    localparam int GW = $clog2(LOCK_CNT + 1);
    localparam logic [EW-1:0] ERR_LIM = EW'(ERR_MAX);
    localparam logic [GW-1:0] GOOD_LIM = GW'(LOCK_CNT);

    typedef struct packed {
        logic [EW-1:0] err;
        logic [GW-1:0] good;
        logic          lock;
    } ld_state_t;

    ld_state_t st_d, st_q;
    logic exceed;

    always_comb begin
        st_d   = st_q;
        exceed = active && (st_q.err >= ERR_LIM);
        if (!run_en) begin
            st_d = '0;
        end else begin
            if (exceed) begin
                st_d.good = '0;
                st_d.lock = 1'b0;
            end else if (resolve) begin
                if (st_q.good != GOOD_LIM) st_d.good = st_q.good + 1'b1;
                st_d.lock = ({1'b0, st_q.good} + 1'b1) >= {1'b0, GOOD_LIM};
            end
            if (resolve || !active)        st_d.err = '0;
            else if (st_q.err != ERR_LIM)  st_d.err = st_q.err + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_q = st_q.lock;

    // R8
    lock_needs_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(resolve && run_en));
    // R9
    overlong_clears_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exceed |=> !lock_q);
endmodule

// File: rtl/pcl_outmap.sv
module pcl_outmap
    import pcl_pkg::*;
(
    input  logic       up,
    input  logic       dn,
    input  logic       pol_swap,
    input  logic       run_en,
    input  logic       lock_in,
    output logic [1:0] pump_code,
    output logic       ext_r,
    output logic       ext_p_pull,
    output logic       lock_out
);
    logic       src_lead, snk_lead;
    pump_code_e code;

    always_comb begin
        src_lead = pol_swap ? dn : up;
        snk_lead = pol_swap ? up : dn;
        if (!run_en) begin
            code       = PUMP_OFF;
            ext_r      = 1'b0;
            ext_p_pull = 1'b0;
            lock_out   = 1'b1;
        end else begin
            code       = src_lead ? PUMP_SRC : (snk_lead ? PUMP_SINK : PUMP_OFF);
            ext_r      = snk_lead;
            ext_p_pull = src_lead;
            lock_out   = lock_in;
        end
        pump_code = code;
    end
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
    parameter int ERR_MAX  = 4,
    parameter int LOCK_CNT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       div_in,
    input  logic       pol_swap,
    input  logic       run_en,
    output logic [1:0] pump_code,
    output logic       ext_r,
    output logic       ext_p_pull,
    output logic       lock_out
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in, rise;
    logic up_q, dn_q, resolve, lock_q;

    assign raw_in = {div_in, ref_in};

    for (genvar g = 0; g < NCH; g++) begin : g_edge
        pcl_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw_in[g]),
            .rise   (rise[g])
        );
    end

    pcl_pfd u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .ref_rise (rise[0]),
        .div_rise (rise[1]),
        .up_q     (up_q),
        .dn_q     (dn_q),
        .resolve  (resolve)
    );

    pcl_lockdet #(.ERR_MAX(ERR_MAX), .LOCK_CNT(LOCK_CNT)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .active  (up_q | dn_q),
        .resolve (resolve),
        .lock_q  (lock_q)
    );

    pcl_outmap u_map (
        .up         (up_q),
        .dn         (dn_q),
        .pol_swap   (pol_swap),
        .run_en     (run_en),
        .lock_in    (lock_q),
        .pump_code  (pump_code),
        .ext_r      (ext_r),
        .ext_p_pull (ext_p_pull),
        .lock_out   (lock_out)
    );

    // R11
    save_clears_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!up_q && !dn_q));
endmodule

// File: tb/pfd_lock_test.sv
module pfd_lock_test;
    localparam int ERR_MAX  = 4;
    localparam int LOCK_CNT = 3;

    logic clk = 1'b0;
    logic rst_n, ref_in, div_in, pol_swap, run_en;
    logic [1:0] pump_code;
    logic ext_r, ext_p_pull, lock_out;

    int total = 0;
    int bad = 0;
    int good_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pfd_lock #(.ERR_MAX(ERR_MAX), .LOCK_CNT(LOCK_CNT)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in),
        .pol_swap(pol_swap), .run_en(run_en), .pump_code(pump_code),
        .ext_r(ext_r), .ext_p_pull(ext_p_pull), .lock_out(lock_out));

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // lead: 0 none, 1 reference leads, 2 divided leads; result {code[1:0], r, p}
    function automatic logic [3:0] exp_out(int lead, bit pol);
        case (lead)
            1:       return pol ? 4'b0110 : 4'b1001;
            2:       return pol ? 4'b1001 : 4'b0110;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk_out(string tag, int lead, bit pol);
        chk(tag, {pump_code, ext_r, ext_p_pull}, exp_out(lead, pol));
    endtask

    // one comparison: leading input rises at step 0, the other d steps later
    task automatic run_cmp(bit ref_first, int d, int gap, bit pol);
        bit prev_lock = (good_cnt >= LOCK_CNT);
        if (d <= ERR_MAX) good_cnt = (good_cnt < LOCK_CNT) ? good_cnt + 1 : LOCK_CNT;
        else              good_cnt = 0;
        for (int i = 0; i <= d + gap; i++) begin
            @(negedge clk);
            if (i >= 1) begin
                int lead = (i <= d) ? (ref_first ? 1 : 2) : 0;
                if (pol) chk_out(lead == 1 ? "R3 R5 ref lead" : "R3 R5 R6 output", lead, pol);
                else     chk_out(lead == 2 ? "R2 R4 div lead" : "R2 R4 R6 output", lead, pol);
                if (d > ERR_MAX && prev_lock && i == ERR_MAX + 1) chk("R9 lock held", lock_out, 1);
                if (d > ERR_MAX && i == ERR_MAX + 2) chk("R9 lock dropped", lock_out, 0);
                if (i == d + gap) chk("R8 R9 lock after cmp", lock_out, good_cnt >= LOCK_CNT);
            end
            if (i == 0) pol_swap = pol;
            ref_in = ref_first ? (i == 0) : (i == d);
            div_in = ref_first ? (i == d) : (i == 0);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; ref_in = 0; div_in = 0; pol_swap = 0; run_en = 1;
        repeat (3) @(negedge clk);
        chk_out("R1 reset outputs", 0, 0);
        chk("R1 reset lock", lock_out, 0);
        rst_n = 1;
        @(negedge clk);
        chk_out("R1 after reset", 0, 0);
        chk("R1 lock after reset", lock_out, 0);

        // R7 simultaneous rises: no pulse
        run_cmp(1, 0, 3, 0);
        // R8 acquisition with small errors
        run_cmp(1, 2, 2, 0);
        run_cmp(0, ERR_MAX, 2, 0);
        run_cmp(1, 1, 2, 1);
        chk("R8 locked", lock_out, 1);
        // R9 overlong lead drops lock
        run_cmp(0, ERR_MAX + 2, 2, 1);

        // R7 second reference rise while lead pending
        for (int i = 0; i <= 7; i++) begin
            @(negedge clk);
            if (i >= 1) chk_out("R7 repeated ref rise", (i <= 5) ? 1 : 0, 0);
            pol_swap = 0;
            ref_in = (i == 0) || (i == 2);
            div_in = (i == 5);
        end
        good_cnt = 0;
        chk("R9 lock after long cmp", lock_out, 0);

        // lock up again, then power save
        for (int k = 0; k < LOCK_CNT; k++) run_cmp(1, 1, 2, 0);
        chk("R8 relocked", lock_out, 1);
        @(negedge clk); ref_in = 1;
        @(negedge clk); ref_in = 0;
        chk_out("R2 pending lead", 1, 0);
        run_en = 0;
        @(negedge clk);
        chk_out("R10 forced outputs", 0, 0);
        chk("R10 forced lock", lock_out, 1);
        div_in = 1;
        @(negedge clk);
        div_in = 0; pol_swap = 1;
        chk_out("R10 forced under activity", 0, 1);
        chk("R10 forced lock under activity", lock_out, 1);
        ref_in = 1;
        @(negedge clk);
        ref_in = 0;
        run_en = 1;
        @(negedge clk);
        chk_out("R11 no residual lead", 0, 1);
        chk("R11 lock requalify", lock_out, 0);
        repeat (2) @(negedge clk);
        chk_out("R11 still idle", 0, 1);
        good_cnt = 0;

        // random comparisons
        for (int n = 0; n < 300; n++) begin
            run_cmp(1'($urandom_range(0, 1)), $urandom_range(0, 7),
                    $urandom_range(1, 4), 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule